// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a word-wide register bus and a small array of one-time-programmable fuse blocks, each 32 bits wide. In this model the fuses are flip-flops. Software sets control and power-switch bits and writes an unlock key. It then writes a word into the fuse window, and the controller burns that word into the addressed block. Burning can only set bits, never clear them. The controller can also store a redundant backup copy, read the block back to verify it, and lock the block permanently. Faults are recorded in a sticky error register, which is cleared by writing 1 to the bits to be cleared in a companion register.

A change to the read-power bit or to either power-switch bit starts a settle counter of `SETTLE_CYC` cycles. Power counts as usable only after that count has elapsed. The programming sequence runs in a three-state machine. `ST_IDLE` accepts bus traffic. A window write that passes every gate moves the machine `ST_IDLE -> ST_BURN`, and a write that fails a gate stays in `ST_IDLE` and raises a reject error. `ST_BURN` ORs the data into the block and always moves to `ST_VERIFY`. `ST_VERIFY` compares the stored copies with the requested word, applies the lock when that is requested and allowed, and returns `ST_VERIFY -> ST_IDLE`. Register reads are served in every state.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset the control (0x20), error (0x24), key (0x2C) and power-switch (0x54) registers read 0, every fuse block is blank and `busy` is low.
- R2: Control bits [4:0] at 0x20, the full 32-bit key at 0x2C and power bits [2:0] at 0x54 read back as written, and each read returns its data with `bus_rvalid` high exactly one cycle after the request.
- R3: A write to block n at 0x1000+4n programs only if all of these hold: the key is 0x8810, power bit2 (program enable) is set, power bit0 is set, power bit1 is clear, and `SETTLE_CYC` cycles have passed since the last power change. Otherwise the array is unchanged and error bit1 is set.
- R4: A program stores the OR of the old block value and the write data.
- R5: With control bit2 (double) set, a program also ORs the data into the backup copy. A read with double set returns the OR of both copies and sets error bit2 if the copies differ.
- R6: A program with control bit4 (lock-on-write) set locks the block. Any later program of that block is rejected with error bit1 and leaves the data unchanged.
- R7: With control bit1 (auto-check) set, the stored copies are compared with the requested word after the burn. A mismatch sets error bit0, and the lock is then withheld.
- R8: A block read while control bit0 (read power) is clear returns the OR of both copies and sets error bit2.
- R9: Error bits [13:0] are sticky. Writing 0x28 clears exactly the bits set in the written value, and 0x3FFF clears them all.
- R10: An accepted program holds `busy` high for two cycles, and bus writes presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| busy | output | 1 | Program sequence in progress |

## Verification
Directed writes take each programming gate away in turn: a missing key, the wrong phase of the power switch, and a settle window that has not yet elapsed. These show that each gate alone blocks a burn and leaves the data untouched. Overlapping programs of one block separate the OR rule from an overwrite, and they also create the readback mismatch that tells the auto-check apart from a plain burn. Programs with and without the double bit, followed by double reads, separate backup-copy handling from single-copy handling. Seeded random mixes of control flags, blocks and sparse data, checked against a bench model, then exercise locking, checking and redundancy together.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
    localparam logic [15:0] A_CTRL  = 16'h0020;
    localparam logic [15:0] A_ERR   = 16'h0024;
    localparam logic [15:0] A_CLR   = 16'h0028;
    localparam logic [15:0] A_KEY   = 16'h002C;
    localparam logic [15:0] A_PWSW  = 16'h0054;
    localparam logic [15:0] A_WIN   = 16'h1000;
    localparam logic [31:0] UNLOCK_KEY = 32'h0000_8810;
    localparam int ERR_W = 14;

    typedef enum logic [1:0] {ST_IDLE, ST_BURN, ST_VERIFY} fsm_t;

    typedef struct packed {
        logic lock_wr;
        logic margin;
        logic dbl;
        logic chk;
        logic rd_pwr;
    } ctrl_t;

    typedef struct packed {
        logic prog_en;
        logic enk2;
        logic enk1;
    } pwsw_t;
endpackage

// File: rtl/fuse_settle.sv
module fuse_settle #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic stable
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= CW'(CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign stable = (cnt_q == '0);
endmodule

// File: rtl/fuse_array.sv
module fuse_array #(
    parameter int NBLK = 24,
    parameter int BW   = 32,
    parameter int IW   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_dbl,
    input  logic [IW-1:0]    wr_idx,
    input  logic [BW-1:0]    wr_data,
    input  logic             lk_set,
    input  logic [IW-1:0]    a_idx,
    output logic [BW-1:0]    a_pri,
    output logic [BW-1:0]    a_bak,
    output logic             a_lock,
    input  logic [IW-1:0]    b_idx,
    output logic [BW-1:0]    b_pri,
    output logic [BW-1:0]    b_bak,
    output logic [NBLK*BW-1:0] pri_flat,
    output logic [NBLK-1:0]  lock_vec
);
    logic [NBLK*BW-1:0] bak_flat;

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic [BW-1:0] pri_q, bak_q;
        logic          lk_q;
        logic          hit;
        assign hit = (wr_idx == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pri_q <= '0;
                bak_q <= '0;
                lk_q  <= 1'b0;
            end else begin
                if (wr_en && hit) begin
                    pri_q <= pri_q | wr_data;
                    if (wr_dbl)
                        bak_q <= bak_q | wr_data;
                end
                if (lk_set && hit)
                    lk_q <= 1'b1;
            end
        end

        assign pri_flat[g*BW +: BW] = pri_q;
        assign bak_flat[g*BW +: BW] = bak_q;
        assign lock_vec[g]          = lk_q;
    end

    always_comb begin
        a_pri  = '0;
        a_bak  = '0;
        a_lock = 1'b0;
        b_pri  = '0;
        b_bak  = '0;
        for (int i = 0; i < NBLK; i++) begin
            if (a_idx == IW'(i)) begin
                a_pri  = pri_flat[i*BW +: BW];
                a_bak  = bak_flat[i*BW +: BW];
                a_lock = lock_vec[i];
            end
            if (b_idx == IW'(i)) begin
                b_pri = pri_flat[i*BW +: BW];
                b_bak = bak_flat[i*BW +: BW];
            end
        end
    end
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int BW = 32,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ok,
    input  logic [IW-1:0] idx,
    input  logic [BW-1:0] data,
    input  logic          dbl,
    input  logic          chk,
    input  logic          lk,
    input  logic [BW-1:0] b_pri,
    input  logic [BW-1:0] b_bak,
    output logic          busy,
    output logic          wr_en,
    output logic          wr_dbl,
    output logic [IW-1:0] wr_idx,
    output logic [BW-1:0] wr_data,
    output logic          lk_set,
    output logic          err_chk,
    output logic          err_rej
);
    fsm_t state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [BW-1:0] data_q;
    logic dbl_q, chk_q, lk_q;
    logic mismatch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            data_q <= '0;
            dbl_q  <= 1'b0;
            chk_q  <= 1'b0;
            lk_q   <= 1'b0;
        end else if (state_q == ST_IDLE && start && ok) begin
            idx_q  <= idx;
            data_q <= data;
            dbl_q  <= dbl;
            chk_q  <= chk;
            lk_q   <= lk;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start && ok) state_d = ST_BURN;
            ST_BURN:   state_d = ST_VERIFY;
            ST_VERIFY: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign mismatch = chk_q && ((b_pri != data_q) || (dbl_q && (b_bak != data_q)));

    always_comb begin
        busy    = 1'b0;
        wr_en   = 1'b0;
        lk_set  = 1'b0;
        err_chk = 1'b0;
        err_rej = 1'b0;
        unique case (state_q)
            ST_IDLE:   err_rej = start && !ok;
            ST_BURN: begin
                busy  = 1'b1;
                wr_en = 1'b1;
            end
            ST_VERIFY: begin
                busy    = 1'b1;
                err_chk = mismatch;
                lk_set  = lk_q && !mismatch;
            end
            default: ;
        endcase
    end

    assign wr_dbl  = dbl_q;
    assign wr_idx  = idx_q;
    assign wr_data = data_q;
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
    import fuse_pkg::*;
#(
    parameter int NBLK       = 24,
    parameter int ADDR_W     = 16,
    parameter int SETTLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              busy
);
    localparam int BW = 32;
    localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1;

    ctrl_t             ctrl_q;
    pwsw_t             pw_q;
    logic [31:0]       key_q;
    logic [ERR_W-1:0]  err_q;
    logic [ERR_W-1:0]  err_set;
    logic [ERR_W-1:0]  clr_mask;

    logic              req_wr, req_rd;
    logic [ADDR_W-1:0] off;
    logic              in_win, blk_ok;
    logic [IW-1:0]     blk_idx;
    logic              stable, restart, prog_ok, pwr_rd_on;

    logic [BW-1:0]     a_pri, a_bak, b_pri, b_bak;
    logic              a_lock;
    logic [NBLK*BW-1:0] pri_flat;
    logic [NBLK-1:0]   lock_vec;

    logic              wr_en, wr_dbl, lk_set, err_chk, err_rej;
    logic [IW-1:0]     wr_idx;
    logic [BW-1:0]     wr_data;

    logic [31:0]       rd_val;
    logic              rd_err;

    assign req_wr  = bus_req && bus_we && !busy;
    assign req_rd  = bus_req && !bus_we;
    assign off     = bus_addr - ADDR_W'(A_WIN);
    assign in_win  = (bus_addr >= ADDR_W'(A_WIN));
    assign blk_ok  = in_win && (off[1:0] == 2'b00) && ((off >> 2) < ADDR_W'(NBLK));
    assign blk_idx = off[IW+1:2];

    assign restart = req_wr && (
        ((bus_addr == ADDR_W'(A_CTRL)) && (bus_wdata[0] != ctrl_q.rd_pwr)) ||
        ((bus_addr == ADDR_W'(A_PWSW)) && (bus_wdata[1:0] != {pw_q.enk2, pw_q.enk1})));

    assign prog_ok = blk_ok && (key_q == UNLOCK_KEY) && pw_q.prog_en &&
                     pw_q.enk1 && !pw_q.enk2 && stable && !a_lock;
    assign pwr_rd_on = ctrl_q.rd_pwr && stable;

    fuse_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .stable  (stable)
    );

    fuse_array #(.NBLK(NBLK), .BW(BW), .IW(IW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_dbl   (wr_dbl),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .lk_set   (lk_set),
        .a_idx    (blk_idx),
        .a_pri    (a_pri),
        .a_bak    (a_bak),
        .a_lock   (a_lock),
        .b_idx    (wr_idx),
        .b_pri    (b_pri),
        .b_bak    (b_bak),
        .pri_flat (pri_flat),
        .lock_vec (lock_vec)
    );

    fuse_seq #(.BW(BW), .IW(IW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (req_wr && in_win),
        .ok      (prog_ok),
        .idx     (blk_idx),
        .data    (bus_wdata),
        .dbl     (ctrl_q.dbl),
        .chk     (ctrl_q.chk),
        .lk      (ctrl_q.lock_wr),
        .b_pri   (b_pri),
        .b_bak   (b_bak),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_dbl  (wr_dbl),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .lk_set  (lk_set),
        .err_chk (err_chk),
        .err_rej (err_rej)
    );

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pw_q   <= '0;
            key_q  <= '0;
        end else if (req_wr) begin
            if (bus_addr == ADDR_W'(A_CTRL)) ctrl_q <= ctrl_t'(bus_wdata[4:0]);
            if (bus_addr == ADDR_W'(A_PWSW)) pw_q   <= pwsw_t'(bus_wdata[2:0]);
            if (bus_addr == ADDR_W'(A_KEY))  key_q  <= bus_wdata;
        end
    end

    // window read path
    always_comb begin
        rd_val = '0;
        rd_err = 1'b0;
        if (blk_ok) begin
            if (!pwr_rd_on) begin
                rd_val = a_pri | a_bak;
                rd_err = 1'b1;
            end else if (ctrl_q.dbl) begin
                rd_val = a_pri | a_bak;
                rd_err = (a_pri != a_bak);
            end else begin
                rd_val = a_pri;
            end
        end
    end

    // sticky errors, set wins over clear
    assign err_set  = {{(ERR_W-3){1'b0}}, req_rd && rd_err, err_rej, err_chk};
    assign clr_mask = (req_wr && bus_addr == ADDR_W'(A_CLR)) ? bus_wdata[ERR_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~clr_mask) | err_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= req_rd;
            if (req_rd) begin
                if (in_win)                            bus_rdata <= rd_val;
                else if (bus_addr == ADDR_W'(A_CTRL))  bus_rdata <= {27'b0, ctrl_q};
                else if (bus_addr == ADDR_W'(A_ERR))   bus_rdata <= {{(32-ERR_W){1'b0}}, err_q};
                else if (bus_addr == ADDR_W'(A_KEY))   bus_rdata <= key_q;
                else if (bus_addr == ADDR_W'(A_PWSW))  bus_rdata <= {29'b0, pw_q};
                else                                   bus_rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk
    import fuse_pkg::*;
#(
    parameter int NBLK   = 24,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rvalid,
    input logic              busy,
    input logic [ERR_W-1:0]  err_q,
    input logic [31:0]       key_q,
    input logic [NBLK-1:0]   lock_vec,
    input logic [NBLK*32-1:0] pri_flat
);
    p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    p_rvalid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    p_key_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(key_q) == UNLOCK_KEY));

    p_only_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pri_flat & $past(pri_flat)) == $past(pri_flat)));

    p_lock_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_we && !busy && bus_addr == ADDR_W'(A_CLR))
        |=> ((err_q & $past(err_q)) == $past(err_q)));

    p_busy_two_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 !busy);
endmodule

bind fuse_ctrl fuse_ctrl_chk #(.NBLK(NBLK), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .busy       (busy),
    .err_q      (err_q),
    .key_q      (key_q),
    .lock_vec   (lock_vec),
    .pri_flat   (pri_flat)
);

// File: tb/sim_fuse_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_ctrl;
    localparam int NB = 24;
    localparam int SC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, busy;

    int n_chk = 0, n_bad = 0;
    logic [31:0] mp [NB];
    logic [31:0] mb [NB];
    logic        ml [NB];
    logic [13:0] exp_err;

    always #2.5 clk = ~clk;

    fuse_ctrl #(.NBLK(NB), .ADDR_W(16), .SETTLE_CYC(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .busy(busy));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic settle();
        repeat (SC + 3) @(negedge clk);
    endtask

    function automatic logic [31:0] blk_addr(input int n);
        return 32'h1000 + 32'(n) * 4;
    endfunction

    // model of a program under full power and key
    task automatic model_prog(input int n, input logic [31:0] d, input logic [4:0] c);
        logic mis;
        if (ml[n]) begin
            exp_err[1] = 1'b1;
        end else begin
            mp[n] = mp[n] | d;
            if (c[2]) mb[n] = mb[n] | d;
            mis = c[1] && ((mp[n] != d) || (c[2] && mb[n] != d));
            if (mis) exp_err[0] = 1'b1;
            else if (c[4]) ml[n] = 1'b1;
        end
    endtask

    function automatic logic [31:0] model_read(input int n, input logic [4:0] c);
        if (c[2]) return mp[n] | mb[n];
        return mp[n];
    endfunction

    task automatic err_is(input string req, input logic [13:0] e);
        logic [31:0] d; logic v;
        rd(16'h0024, d, v);
        check(req, d, {18'b0, e});
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d; logic v;
        logic [4:0] c;
        void'($urandom(32'd1234));
        for (int i = 0; i < NB; i++) begin mp[i] = '0; mb[i] = '0; ml[i] = 1'b0; end
        exp_err = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 busy", {31'b0, busy}, 32'h0);
        rd(16'h0020, d, v); check("R1 ctrl", d, 32'h0);
        rd(16'h0024, d, v); check("R1 err", d, 32'h0);
        rd(16'h002C, d, v); check("R1 key", d, 32'h0);
        rd(16'h0054, d, v); check("R1 pwsw", d, 32'h0);

        // R2 readback and latency
        wr(16'h0020, 32'hFFFF_FFFF);
        rd(16'h0020, d, v); check("R2 ctrl", d, 32'h1F); check("R2 rvalid", {31'b0, v}, 32'h1);
        wr(16'h002C, 32'hDEAD_BEEF);
        rd(16'h002C, d, v); check("R2 key", d, 32'hDEAD_BEEF);
        wr(16'h0054, 32'h0000_0006);
        rd(16'h0054, d, v); check("R2 pwsw", d, 32'h6);
        wr(16'h0020, 0); wr(16'h0054, 0); wr(16'h002C, 0);
        @(negedge clk); check("R2 rvalid low", {31'b0, bus_rvalid}, 32'h0);

        // R8 read without power
        rd(blk_addr(0), d, v); check("R8 unpowered data", d, 0);
        err_is("R8 unpowered err", 14'h4);
        wr(16'h0028, 32'h4); err_is("R9 clear", 14'h0);

        // R3 no key
        wr(16'h0054, 32'h5); settle();
        wr(blk_addr(1), 32'hA5);
        err_is("R3 no key", 14'h2);
        wr(16'h0020, 32'h1); settle();
        rd(blk_addr(1), d, v); check("R3 no key data", d, 0);
        wr(16'h0028, 32'h3FFF);

        // R3 settle window not elapsed
        wr(16'h002C, 32'h8810);
        wr(16'h0054, 32'h4);
        wr(16'h0054, 32'h5);
        wr(blk_addr(1), 32'hA5);
        err_is("R3 unsettled", 14'h2);
        wr(16'h0028, 32'h3FFF);
        // R3 wrong power phase
        wr(16'h0054, 32'h7); settle();
        wr(blk_addr(1), 32'hA5);
        err_is("R3 enk2 set", 14'h2);
        wr(16'h0054, 32'h5); settle();
        rd(blk_addr(1), d, v); check("R3 data untouched", d, 0);
        wr(16'h0028, 32'h3FFF);

        // R4 OR semantics
        wr(blk_addr(3), 32'hF0);
        wr(blk_addr(3), 32'h0F);
        rd(blk_addr(3), d, v); check("R4 or", d, 32'hFF);
        err_is("R4 no err", 14'h0);
        mp[3] = 32'hFF;

        // R7 auto-check mismatch
        wr(16'h0020, 32'h3);
        wr(blk_addr(3), 32'h100);
        err_is("R7 mismatch", 14'h1);
        wr(16'h0028, 32'h3FFF); mp[3] = 32'h1FF;

        // R7 lock withheld after mismatch
        wr(16'h0020, 32'h13);
        wr(blk_addr(3), 32'h2);
        err_is("R7 lock withheld err", 14'h1);
        wr(16'h0028, 32'h3FFF);
        wr(16'h0020, 32'h1);
        wr(blk_addr(3), 32'h200);
        err_is("R7 block still open", 14'h0);
        rd(blk_addr(3), d, v); check("R7 data", d, 32'h3FF);
        mp[3] = 32'h3FF;

        // R5 double storage
        wr(16'h0020, 32'h5);
        wr(blk_addr(5), 32'h1234);
        rd(blk_addr(5), d, v); check("R5 dbl read", d, 32'h1234);
        err_is("R5 copies agree", 14'h0);
        mp[5] = 32'h1234; mb[5] = 32'h1234;
        wr(16'h0020, 32'h1);
        wr(blk_addr(6), 32'h1);
        wr(16'h0020, 32'h5);
        rd(blk_addr(6), d, v); check("R5 dbl differ data", d, 32'h1);
        err_is("R5 dbl differ err", 14'h4);
        wr(16'h0028, 32'h3FFF); mp[6] = 32'h1;

        // R6 lock
        wr(16'h0020, 32'h11);
        wr(blk_addr(7), 32'h3);
        wr(16'h0020, 32'h1);
        wr(blk_addr(7), 32'hC);
        err_is("R6 locked reject", 14'h2);
        rd(blk_addr(7), d, v); check("R6 locked data", d, 32'h3);
        wr(16'h0028, 32'h3FFF);
        mp[7] = 32'h3; ml[7] = 1'b1;

        // R9 partial clear
        wr(blk_addr(7), 32'h8);            // bit1
        wr(16'h0020, 32'h0); settle();
        rd(blk_addr(0), d, v);             // bit2
        wr(16'h0020, 32'h3); settle();
        wr(blk_addr(3), 32'h1);            // bit0 (stored 0x3FF)
        err_is("R9 all set", 14'h7);
        wr(16'h0028, 32'h2);
        err_is("R9 partial", 14'h5);
        wr(16'h0028, 32'h3FFF);
        err_is("R9 full", 14'h0);

        // R10 busy window and ignored writes
        wr(16'h0020, 32'h1);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = blk_addr(9); bus_wdata = 32'h40;
        @(negedge clk);
        check("R10 busy 1", {31'b0, busy}, 1);
        bus_addr = 16'h0020; bus_wdata = 32'h1F;
        @(negedge clk);
        check("R10 busy 2", {31'b0, busy}, 1);
        bus_req = 0; bus_we = 0;
        @(negedge clk);
        check("R10 busy done", {31'b0, busy}, 0);
        rd(16'h0020, d, v); check("R10 write ignored", d, 32'h1);
        mp[9] = 32'h40;

        // random mix against the model
        exp_err = '0;
        for (int k = 0; k < 300; k++) begin
            int n;
            logic [31:0] dat;
            n = int'($urandom % NB);
            c = {($urandom % 8) == 0, 1'b0, 1'(($urandom)), 1'(($urandom)), 1'b1};
            wr(16'h0020, {27'b0, c});
            if (($urandom % 10) < 6) begin
                dat = $urandom & $urandom & $urandom;
                wr(blk_addr(n), dat);
                model_prog(n, dat, c);
            end else begin
                rd(blk_addr(n), d, v);
                check("R5 R4 random read", d, model_read(n, c));
                if (c[2] && mp[n] != mb[n]) exp_err[2] = 1'b1;
            end
            err_is("R6 R7 random err", exp_err);
            wr(16'h0028, 32'h3FFF);
            exp_err = '0;
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule